// File: doc/BRIEF.md
# Integer Execution Unit with Selectable Flag Update

This block is the single-issue integer execution stage of a 64-bit core. Each cycle it may accept one operation. The operation carries two source register indices with their operand values, a destination index, a 3-bit operation code, a set-flags bit and the current NZCV condition flags. One clock edge later the block presents the result, the destination index, a result write enable, the new flag vector and a flag write enable. These outputs go to the register file and to the flag storage, both of which sit outside this block.

Register index 31 reads as zero and takes no writes, so no separate compare, test or move operations exist. A compare is a flag-setting subtract whose destination is 31. A test is a flag-setting AND whose destination is 31. A move is an add with index 31 as the second source. The set-flags bit decides, for each operation, whether the flags are written. This keeps flag write traffic down to the operations whose flags are actually used.

Flag vector layout on `flagsIn` and `flagsOut` is bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.

Top module: `int_exu`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract (A minus B), 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR. `resData` carries the 64-bit result of the operation.
- R2: Outputs are registered. An operation presented with `issueValid` high at a rising edge appears on the outputs right after that edge, and they hold until the next edge.
- R3: A source whose index is 31 is read as zero, whatever its value input carries.
- R4: `resWrEn` is high only for a valid operation with code 0 to 6 and a destination index other than 31. For destination 31, `resData` still shows the computed result.
- R5: `flagWrEn` is high only for a valid operation with `setFlags` high and code 0 to 4. Whenever `flagWrEn` is low, `flagsOut` equals the `flagsIn` value presented with that operation.
- R6: When flags are written, N is result bit 63 and Z is high exactly when the result is all zeros.
- R7: When flags are written by codes 0 to 3, C is the carry out of bit 63 (for subtract, 1 means no borrow) and V is signed two's-complement overflow. Code 4 writes C = 0 and V = 0.
- R8: Add-with-carry adds the incoming C flag. Subtract-with-borrow computes A - B - (1 - C) with the incoming C flag.
- R9: OR and XOR never write flags, even with `setFlags` high.
- R10: Code 7, or `issueValid` low, writes neither result nor flags.
- R11: While synchronous active-high `rst` is asserted, every output register is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Operation code (see R1) |
| setFlags | input | 1 | Request flag update |
| srcAIdx | input | 5 | First source register index |
| srcAVal | input | 64 | First source value from the register file |
| srcBIdx | input | 5 | Second source register index |
| srcBVal | input | 64 | Second source value from the register file |
| dstIdx | input | 5 | Destination register index |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| resWrEn | output | 1 | Result write enable |
| resIdx | output | 5 | Destination index of the result |
| resData | output | 64 | Result value |
| flagWrEn | output | 1 | Flag write enable |
| flagsOut | output | 4 | Outgoing flags {N,Z,C,V} |

## Verification
All state is one rank of output registers, so any wrong internal value shows on the ports in the very cycle after the operation that caused it. There is no slow drift to wait for. A decode fault shows up as a stray write enable, for example a write to index 31 or a flag write from OR. A datapath fault shows up as a wrong result or a wrong C or V bit. The cases that tell such faults apart are borrow and overflow on the 64-bit boundary, carry-in taken from the flags, and index 31 used as a source or as the destination.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_ORR = 3'd5,
    OP_XOR = 3'd6,
    OP_NOP = 3'd7
  } opCode_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_ORR = 2'd1,
    LOG_XOR = 2'd2
  } logicSel_e;

  // Strobes from decode to the datapath
  typedef struct packed {
    logic      useAdder;
    logic      invertB;
    cinSel_e   cinSel;
    logicSel_e logicSel;
    logic      wrResult;
    logic      wrFlags;
  } exuStrobes_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issueValid,
  input  logic [2:0]       opCode,
  input  logic             setFlags,
  input  logic [IDX_W-1:0] dstIdx,
  output exuStrobes_t      strobes
);

  localparam logic [IDX_W-1:0] ZERO_IDX = {IDX_W{1'b1}};

  opCode_e opDec;
  logic    legalOp;
  logic    flagCapable;

  assign opDec = opCode_e'(opCode);

  always_comb begin
    strobes          = '0;
    strobes.cinSel   = CIN_ZERO;
    strobes.logicSel = LOG_AND;
    legalOp          = 1'b1;
    flagCapable      = 1'b0;
    unique case (opDec)
      OP_ADD: begin strobes.useAdder = 1'b1; flagCapable = 1'b1; end
      OP_ADC: begin strobes.useAdder = 1'b1; strobes.cinSel = CIN_FLAG; flagCapable = 1'b1; end
      OP_SUB: begin
        strobes.useAdder = 1'b1; strobes.invertB = 1'b1;
        strobes.cinSel = CIN_ONE; flagCapable = 1'b1;
      end
      OP_SBC: begin
        strobes.useAdder = 1'b1; strobes.invertB = 1'b1;
        strobes.cinSel = CIN_FLAG; flagCapable = 1'b1;
      end
      OP_AND: begin strobes.logicSel = LOG_AND; flagCapable = 1'b1; end
      OP_ORR: strobes.logicSel = LOG_ORR;
      OP_XOR: strobes.logicSel = LOG_XOR;
      OP_NOP: legalOp = 1'b0;
      default: legalOp = 1'b0;
    endcase
    strobes.wrResult = issueValid && legalOp && (dstIdx != ZERO_IDX);
    strobes.wrFlags  = issueValid && setFlags && flagCapable;
  end

  // R9: OR/XOR decode must never request a flag write
  assert_or_xor_noflag_R9: assert property (@(posedge clk) disable iff (rst)
    (opCode == 3'd5 || opCode == 3'd6) |-> !strobes.wrFlags);

  // R10: a NOP code requests neither write
  assert_nop_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (opCode == 3'd7) |-> (!strobes.wrFlags && !strobes.wrResult));

endmodule

// File: rtl/exu_dpath.sv
module exu_dpath
  import exu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  exuStrobes_t       strobes,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [DATA_W-1:0] srcAVal,
  input  logic [IDX_W-1:0]  srcBIdx,
  input  logic [DATA_W-1:0] srcBVal,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [3:0]        flagsIn,
  output logic              resWrEn,
  output logic [IDX_W-1:0]  resIdx,
  output logic [DATA_W-1:0] resData,
  output logic              flagWrEn,
  output logic [3:0]        flagsOut
);

  localparam int NUM_SRC = 2;
  localparam int MSB     = DATA_W - 1;
  localparam logic [IDX_W-1:0] ZERO_IDX = {IDX_W{1'b1}};

  logic [IDX_W-1:0]  srcIdxArr [NUM_SRC];
  logic [DATA_W-1:0] srcValArr [NUM_SRC];
  logic [DATA_W-1:0] opnd      [NUM_SRC];

  assign srcIdxArr[0] = srcAIdx;
  assign srcIdxArr[1] = srcBIdx;
  assign srcValArr[0] = srcAVal;
  assign srcValArr[1] = srcBVal;

  // Index 31 reads as zero on every source port
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_srcMask
    assign opnd[g] = (srcIdxArr[g] == ZERO_IDX) ? '0 : srcValArr[g];
  end

  logic [DATA_W-1:0] bOp;
  logic              carryIn;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] result;
  logic [3:0]        newFlags;

  assign bOp = strobes.invertB ? ~opnd[1] : opnd[1];

  always_comb begin
    unique case (strobes.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsIn[FLAG_C];
      default:  carryIn = 1'b0;
    endcase
  end

  assign sumFull = {1'b0, opnd[0]} + {1'b0, bOp} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    unique case (strobes.logicSel)
      LOG_ORR: logicRes = opnd[0] | opnd[1];
      LOG_XOR: logicRes = opnd[0] ^ opnd[1];
      default: logicRes = opnd[0] & opnd[1];
    endcase
  end

  assign result = strobes.useAdder ? sumFull[MSB:0] : logicRes;

  always_comb begin
    newFlags         = '0;
    newFlags[FLAG_N] = result[MSB];
    newFlags[FLAG_Z] = ~|result;
    if (strobes.useAdder) begin
      newFlags[FLAG_C] = sumFull[DATA_W];
      newFlags[FLAG_V] = (opnd[0][MSB] == bOp[MSB]) && (sumFull[MSB] != opnd[0][MSB]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resWrEn  <= 1'b0;
      resIdx   <= '0;
      resData  <= '0;
      flagWrEn <= 1'b0;
      flagsOut <= '0;
    end else begin
      resWrEn  <= strobes.wrResult;
      resIdx   <= dstIdx;
      resData  <= result;
      flagWrEn <= strobes.wrFlags;
      flagsOut <= strobes.wrFlags ? newFlags : flagsIn;
    end
  end

  // R4: no write ever targets index 31
  assert_no_zero_write_R4: assert property (@(posedge clk) disable iff (rst)
    resWrEn |-> (resIdx != ZERO_IDX));

  // R6: written Z and N agree with the presented result
  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    flagWrEn |-> (flagsOut[FLAG_Z] == (resData == '0)));
  assert_neg_flag_R6: assert property (@(posedge clk) disable iff (rst)
    flagWrEn |-> (flagsOut[FLAG_N] == resData[MSB]));

  // R5: without a flag write the incoming flags pass through unchanged
  assert_flags_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !flagWrEn) |-> (flagsOut == $past(flagsIn)));

endmodule

// File: rtl/int_exu.sv
module int_exu
  import exu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  input  logic [2:0]        opCode,
  input  logic              setFlags,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [DATA_W-1:0] srcAVal,
  input  logic [IDX_W-1:0]  srcBIdx,
  input  logic [DATA_W-1:0] srcBVal,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [3:0]        flagsIn,
  output logic              resWrEn,
  output logic [IDX_W-1:0]  resIdx,
  output logic [DATA_W-1:0] resData,
  output logic              flagWrEn,
  output logic [3:0]        flagsOut
);

  exuStrobes_t strobes;

  exu_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .opCode     (opCode),
    .setFlags   (setFlags),
    .dstIdx     (dstIdx),
    .strobes    (strobes)
  );

  exu_dpath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .srcAIdx  (srcAIdx),
    .srcAVal  (srcAVal),
    .srcBIdx  (srcBIdx),
    .srcBVal  (srcBVal),
    .dstIdx   (dstIdx),
    .flagsIn  (flagsIn),
    .resWrEn  (resWrEn),
    .resIdx   (resIdx),
    .resData  (resData),
    .flagWrEn (flagWrEn),
    .flagsOut (flagsOut)
  );

  // R2: a valid legal op to a real register is written one edge later
  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (issueValid && opCode != 3'd7 && dstIdx != {IDX_W{1'b1}}) |=> resWrEn);

  // R10: an idle cycle produces no writes on the next edge
  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (rst)
    !issueValid |=> (!resWrEn && !flagWrEn));

endmodule

// File: tb/tb_int_exu.sv
module tb_int_exu;

  logic        clk = 1'b0;
  logic        rst;
  logic        issueValid;
  logic [2:0]  opCode;
  logic        setFlags;
  logic [4:0]  srcAIdx, srcBIdx, dstIdx;
  logic [63:0] srcAVal, srcBVal;
  logic [3:0]  flagsIn;
  logic        resWrEn, flagWrEn;
  logic [4:0]  resIdx;
  logic [63:0] resData;
  logic [3:0]  flagsOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  int_exu dut (.*);

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Reference from the requirements: returns {flags, result}
  function automatic logic [67:0] refModel(logic [2:0] op, logic [63:0] a, logic [63:0] b,
                                           logic cIn);
    logic [63:0] r;
    logic c, v;
    logic [65:0] wideA, wideB;
    logic signed [65:0] sa, sb, sr;
    c = 1'b0; v = 1'b0;
    wideA = {2'b0, a}; wideB = {2'b0, b};
    sa = $signed({{2{a[63]}}, a}); sb = $signed({{2{b[63]}}, b});
    case (op)
      3'd0, 3'd1: begin
        logic ci;
        ci = (op == 3'd1) ? cIn : 1'b0;
        r = a + b + 64'(ci);
        c = (wideA + wideB + 66'(ci)) > 66'h0_FFFF_FFFF_FFFF_FFFF;
        sr = sa + sb + 66'(ci);
        v = (sr > 66'sd9223372036854775807) || (sr < -66'sd9223372036854775808);
      end
      3'd2, 3'd3: begin
        logic bw;
        bw = (op == 3'd3) ? ~cIn : 1'b0;
        r = a - b - 64'(bw);
        c = wideA >= (wideB + 66'(bw));
        sr = sa - sb - 66'(bw);
        v = (sr > 66'sd9223372036854775807) || (sr < -66'sd9223372036854775808);
      end
      3'd4: r = a & b;
      3'd5: r = a | b;
      3'd6: r = a ^ b;
      default: r = '0;
    endcase
    return {r[63], (r == 0), c, v, r};
  endfunction

  task automatic runOp(string rq, logic vld, logic [2:0] op, logic sf,
                       logic [4:0] ai, logic [63:0] av, logic [4:0] bi, logic [63:0] bv,
                       logic [4:0] di, logic [3:0] fin);
    logic [63:0] ea, eb;
    logic [67:0] m;
    logic expWr, expFw;
    @(negedge clk);
    issueValid = vld; opCode = op; setFlags = sf;
    srcAIdx = ai; srcAVal = av; srcBIdx = bi; srcBVal = bv; dstIdx = di; flagsIn = fin;
    ea = (ai == 5'd31) ? 64'd0 : av;   // R3
    eb = (bi == 5'd31) ? 64'd0 : bv;
    m = refModel(op, ea, eb, fin[1]);
    expWr = vld && (op != 3'd7) && (di != 5'd31);
    expFw = vld && sf && (op <= 3'd4);
    @(posedge clk); #1;
    issueValid = 1'b0;
    chk(rq, "resWrEn", 64'(resWrEn), 64'(expWr));
    chk(rq, "flagWrEn", 64'(flagWrEn), 64'(expFw));
    chk(rq, "flagsOut", 64'(flagsOut), 64'(expFw ? m[67:64] : fin));
    if (op != 3'd7) chk(rq, "resData", resData, m[63:0]);
    if (expWr) chk(rq, "resIdx", 64'(resIdx), 64'(di));
  endtask

  task automatic testReset;
    rst = 1'b1; issueValid = 1'b1; opCode = 3'd0; setFlags = 1'b1;
    srcAIdx = 5'd1; srcAVal = 64'd5; srcBIdx = 5'd2; srcBVal = 64'd6;
    dstIdx = 5'd3; flagsIn = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "resWrEn", 64'(resWrEn), 64'd0);
    chk("R11", "flagWrEn", 64'(flagWrEn), 64'd0);
    chk("R11", "resData", resData, 64'd0);
    chk("R11", "flagsOut", 64'(flagsOut), 64'd0);
    @(negedge clk); rst = 1'b0; issueValid = 1'b0;
  endtask

  task automatic testPlainOps;   // R1 R2 R5: no flag update without setFlags
    runOp("R1", 1, 3'd0, 0, 5'd1, 64'd5, 5'd2, 64'd7, 5'd3, 4'b1010);
    chk("R1", "add sum", resData, 64'd12);
    runOp("R1", 1, 3'd2, 0, 5'd1, 64'd10, 5'd2, 64'd3, 5'd4, 4'b0101);
    chk("R1", "sub diff", resData, 64'd7);
    runOp("R1", 1, 3'd4, 0, 5'd1, 64'hF0F0, 5'd2, 64'hFF00, 5'd5, 4'b0011);
    runOp("R1", 1, 3'd5, 0, 5'd1, 64'hF0F0, 5'd2, 64'h0F0F, 5'd6, 4'b0000);
    runOp("R1", 1, 3'd6, 0, 5'd1, 64'hFFFF, 5'd2, 64'h00FF, 5'd7, 4'b1111);
    runOp("R2", 1, 3'd0, 1, 5'd8, 64'hDEAD_0000, 5'd9, 64'hBEEF, 5'd10, 4'b0000);
  endtask

  task automatic testArithFlags;  // R6 R7
    runOp("R7", 1, 3'd0, 1, 5'd1, 64'h7FFF_FFFF_FFFF_FFFF, 5'd2, 64'd1, 5'd3, 4'b0000);
    chk("R7", "overflow flags", 64'(flagsOut), 64'b1001);
    runOp("R6", 1, 3'd0, 1, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd2, 64'd1, 5'd3, 4'b0000);
    chk("R6", "zero+carry flags", 64'(flagsOut), 64'b0110);
    runOp("R7", 1, 3'd2, 1, 5'd1, 64'd3, 5'd2, 64'd10, 5'd3, 4'b0010);
    chk("R7", "borrow flags", 64'(flagsOut), 64'b1000);
    runOp("R7", 1, 3'd2, 1, 5'd1, 64'h8000_0000_0000_0000, 5'd2, 64'd1, 5'd3, 4'b0000);
    chk("R7", "sub overflow flags", 64'(flagsOut), 64'b0011);
  endtask

  task automatic testCarryIn;     // R8
    runOp("R8", 1, 3'd1, 0, 5'd1, 64'd10, 5'd2, 64'd20, 5'd3, 4'b0010);
    chk("R8", "adc with C=1", resData, 64'd31);
    runOp("R8", 1, 3'd1, 1, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd2, 64'd0, 5'd3, 4'b0010);
    runOp("R8", 1, 3'd3, 0, 5'd1, 64'd10, 5'd2, 64'd3, 5'd3, 4'b0000);
    chk("R8", "sbc with C=0", resData, 64'd6);
    runOp("R8", 1, 3'd3, 1, 5'd1, 64'd10, 5'd2, 64'd3, 5'd3, 4'b0010);
    chk("R8", "sbc with C=1", resData, 64'd7);
  endtask

  task automatic testZeroReg;     // R3 R4: compare, test, move
    runOp("R4", 1, 3'd2, 1, 5'd1, 64'd42, 5'd2, 64'd42, 5'd31, 4'b1001);
    chk("R4", "compare equal flags", 64'(flagsOut), 64'b0110);
    chk("R4", "compare no write", 64'(resWrEn), 64'd0);
    runOp("R7", 1, 3'd4, 1, 5'd1, 64'h8000_0000_0000_0001, 5'd2, 64'h8000_0000_0000_0000,
          5'd31, 4'b0011);
    chk("R7", "test flags", 64'(flagsOut), 64'b1000);
    runOp("R3", 1, 3'd0, 0, 5'd4, 64'h1234_5678, 5'd31, 64'hFFFF_FFFF, 5'd5, 4'b0000);
    chk("R3", "move value", resData, 64'h1234_5678);
    runOp("R3", 1, 3'd2, 1, 5'd31, 64'hAAAA, 5'd6, 64'd1, 5'd7, 4'b0000);
    chk("R3", "negate from zero reg", resData, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic testNoFlagOps;   // R9 R10
    runOp("R9", 1, 3'd5, 1, 5'd1, 64'd0, 5'd2, 64'd0, 5'd3, 4'b0101);
    chk("R9", "orr flags kept", 64'(flagsOut), 64'b0101);
    runOp("R9", 1, 3'd6, 1, 5'd1, 64'h5, 5'd2, 64'h5, 5'd3, 4'b1010);
    chk("R9", "xor flag enable", 64'(flagWrEn), 64'd0);
    runOp("R10", 1, 3'd7, 1, 5'd1, 64'd1, 5'd2, 64'd2, 5'd3, 4'b1100);
    runOp("R10", 0, 3'd0, 1, 5'd1, 64'd1, 5'd2, 64'd2, 5'd3, 4'b0011);
    runOp("R5", 1, 3'd2, 0, 5'd1, 64'd1, 5'd2, 64'd1, 5'd31, 4'b1111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testPlainOps();
    testArithFlags();
    testCarryIn();
    testZeroReg();
    testNoFlagOps();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule